// File: doc/BRIEF.md
# Modem Host Task Handshake Controller

This block is the microcontroller-facing control logic of a data-pump modem. The host reaches four byte-wide registers over a simple read/write strobe bus: a task command register, a multi-byte data buffer, a status register and a mode register. A single buffer-free flag paces the host against the modem. The host fills the buffer, issues a task, and may then prepare the next task while the modem finishes the current one. Completion is signalled by the flag returning high together with an interrupt flag.

In transmit mode a data task streams buffered bytes, starting with byte 0, to a downstream interleave store through a valid/ready port. The ready input models the free room in that store. In receive mode a data task waits until the de-interleave side reports enough bits. It then accepts decoded bytes in order into the buffer, and the host reads them back starting with byte 0. A sync-load task publishes two comparison bytes that were placed in the buffer before the task was issued. A reset task aborts any work in flight at any time.

Top module: `modem_task_ctrl`

## Requirements
- R1: After rst_n is released, the status register reads 0x01, irq_n is 1, tx_valid is 0, rx_take is 0 and sync_load is 0.
- R2: Register addresses are 0 command, 1 data buffer, 2 status and 3 mode. Status bit 0 is the buffer-free flag, bit 1 is IRQ and bit 7 echoes the mode direction. Mode bit 7 selects transmit (1) or receive (0), and mode bit 0 enables the interrupt pin. A read returns its value on host_rdata from the clock edge that samples host_rd.
- R3: Writing task code 2 (TSO), 3 (LFSB), 4 (single byte) or 5 (eight-byte block) while buffer-free is 1 clears buffer-free at that edge. Codes 0 (NULL), 6 and 7 change nothing.
- R4: While buffer-free is 0, task writes other than NULL and RESET are ignored, data buffer writes are ignored, and data buffer reads leave host_rdata at its previous value.
- R5: In transmit mode a data task drives tx_valid from the cycle after the command, starting with byte 0 and advancing one byte per edge on which tx_ready is 1. While tx_ready is 0, tx_valid and tx_byte hold.
- R6: A single-byte task moves exactly 1 byte, a block task moves exactly 8 bytes, and TSO moves none.
- R7: On the edge that accepts the last byte of a task, buffer-free and IRQ become 1, and the buffer write and read positions restart at byte 0.
- R8: irq_n is 0 exactly when IRQ is 1 and the interrupt enable is 1.
- R9: Reading status returns the value before the read and clears IRQ. A completion on the same edge wins over the clear.
- R10: In receive mode rx_take is 1 only while a data task is pending and rx_enough is 1. Bytes taken with rx_valid are stored in arrival order, and the host reads byte 0 first.
- R11: An LFSB task sets sync_word to {byte 0, byte 1} of the buffer and pulses sync_load for one cycle, on the second edge after the command. Completion happens on the same edge.
- R12: Task code 1 (RESET) is honoured at any time. It stops any transfer, sets buffer-free to 1, clears IRQ and restarts the buffer positions.
- R13: A mode write changes the direction bit only while buffer-free is 1. The interrupt enable bit is always written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| irq_n | output | 1 | Active-low interrupt |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Interleave store has room |
| tx_byte | output | 8 | Transmit byte |
| rx_enough | input | 1 | De-interleave store holds enough bits |
| rx_valid | input | 1 | Decoded byte available |
| rx_byte | input | 8 | Decoded byte |
| rx_take | output | 1 | Decoded byte is accepted when rx_valid is 1 |
| sync_load | output | 1 | One-cycle pulse: sync_word updated |
| sync_word | output | 16 | Frame sync comparison bytes |

## Verification
A wrong sequencer state appears at the ports within one cycle of the command write. Either tx_valid or rx_take is asserted when it should not be, or a status read shows buffer-free at the wrong level. A miscounted transfer shows up as early or late completion: buffer-free and irq_n change an edge away from the last accepted byte. A corrupted buffer position shows up as out-of-order bytes on tx_byte or on host data reads. A data write that is wrongly accepted while busy stays hidden until a later sync-load task exposes the overwritten byte on sync_word.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

    typedef enum logic [1:0] {
        A_CMD  = 2'd0,
        A_DATA = 2'd1,
        A_STAT = 2'd2,
        A_MODE = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        T_NULL  = 3'd0,
        T_RESET = 3'd1,
        T_TSO   = 3'd2,
        T_LFSB  = 3'd3,
        T_BYTE  = 3'd4,
        T_BLOCK = 3'd5
    } task_code_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_TX,
        S_RX,
        S_FIN
    } seq_e;

    localparam int unsigned LFSB_BYTES = 2;

endpackage

// File: rtl/mtc_task_decode.sv
module mtc_task_decode
    import mtc_pkg::*;
#(
    parameter int unsigned BLOCK_LEN = 8,
    parameter int unsigned CNT_W     = 4
) (
    input  logic [2:0]       code,
    output logic             is_issue,
    output logic             is_reset,
    output logic             is_data,
    output logic [CNT_W-1:0] nbytes
);

    always_comb begin
        is_issue = 1'b0;
        is_reset = 1'b0;
        is_data  = 1'b0;
        nbytes   = '0;
        unique case (code)
            T_RESET: is_reset = 1'b1;
            T_TSO:   is_issue = 1'b1;
            T_LFSB: begin
                is_issue = 1'b1;
                nbytes   = CNT_W'(LFSB_BYTES);
            end
            T_BYTE: begin
                is_issue = 1'b1;
                is_data  = 1'b1;
                nbytes   = CNT_W'(1);
            end
            T_BLOCK: begin
                is_issue = 1'b1;
                is_data  = 1'b1;
                nbytes   = CNT_W'(BLOCK_LEN);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mtc_databuf.sv
module mtc_databuf #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [DW-1:0]       wdata,
    output logic [DEPTH*DW-1:0] flat
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [DW-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else if (we && waddr == AW'(g)) begin
                cell_q <= wdata;
            end
        end
        assign flat[g*DW +: DW] = cell_q;
    end

endmodule

// File: rtl/modem_task_ctrl.sv
module modem_task_ctrl
    import mtc_pkg::*;
#(
    parameter int unsigned DW        = 8,
    parameter int unsigned DEPTH     = 8,
    parameter int unsigned BLOCK_LEN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [1:0]    host_addr,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          irq_n,
    output logic          tx_valid,
    input  logic          tx_ready,
    output logic [DW-1:0] tx_byte,
    input  logic          rx_enough,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    output logic          rx_take,
    output logic          sync_load,
    output logic [2*DW-1:0] sync_word
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    typedef struct packed {
        seq_e            st;
        logic            bfree;
        logic            irq;
        logic            tx_mode;
        logic            irqen;
        logic [PW-1:0]   wr_ptr;
        logic [PW-1:0]   rd_ptr;
        logic [PW-1:0]   xcnt;
        logic [PW-1:0]   xlen;
        logic [DW-1:0]   rdata;
        logic [2*DW-1:0] sync_word;
        logic            sync_load;
    } ctl_t;

    ctl_t r_q, r_d;

    logic                buf_we;
    logic [AW-1:0]       buf_waddr;
    logic [DW-1:0]       buf_wdata;
    logic [DEPTH*DW-1:0] buf_flat;
    logic [DW-1:0]       mem [DEPTH];

    logic          dec_issue, dec_reset, dec_data;
    logic [PW-1:0] dec_nbytes;
    logic [DW-1:0] status_v;
    logic          last_beat;

    mtc_databuf #(.DW(DW), .DEPTH(DEPTH)) i_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .flat  (buf_flat)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
        assign mem[g] = buf_flat[g*DW +: DW];
    end

    mtc_task_decode #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(PW)) i_dec (
        .code     (host_wdata[2:0]),
        .is_issue (dec_issue),
        .is_reset (dec_reset),
        .is_data  (dec_data),
        .nbytes   (dec_nbytes)
    );

    always_comb begin
        status_v       = '0;
        status_v[0]    = r_q.bfree;
        status_v[1]    = r_q.irq;
        status_v[DW-1] = r_q.tx_mode;
    end

    assign last_beat = (r_q.xcnt == r_q.xlen - PW'(1));

    always_comb begin
        r_d           = r_q;
        r_d.sync_load = 1'b0;
        buf_we        = 1'b0;
        buf_waddr     = '0;
        buf_wdata     = '0;

        // host reads: value before this edge's updates
        if (host_rd) begin
            unique case (host_addr)
                A_STAT: begin
                    r_d.rdata = status_v;
                    r_d.irq   = 1'b0;
                end
                A_MODE: begin
                    r_d.rdata       = '0;
                    r_d.rdata[DW-1] = r_q.tx_mode;
                    r_d.rdata[0]    = r_q.irqen;
                end
                A_DATA: begin
                    if (r_q.bfree) begin
                        r_d.rdata = mem[r_q.rd_ptr[AW-1:0]];
                        if (r_q.rd_ptr < PW'(DEPTH)) begin
                            r_d.rd_ptr = r_q.rd_ptr + PW'(1);
                        end
                    end
                end
                default: r_d.rdata = '0;
            endcase
        end

        // task sequencing
        unique case (r_q.st)
            S_TX: begin
                if (tx_ready) begin
                    r_d.xcnt = r_q.xcnt + PW'(1);
                    if (last_beat) begin
                        r_d.st     = S_IDLE;
                        r_d.bfree  = 1'b1;
                        r_d.irq    = 1'b1;
                        r_d.wr_ptr = '0;
                        r_d.rd_ptr = '0;
                    end
                end
            end
            S_RX: begin
                if (rx_enough && rx_valid) begin
                    buf_we    = 1'b1;
                    buf_waddr = r_q.xcnt[AW-1:0];
                    buf_wdata = rx_byte;
                    r_d.xcnt  = r_q.xcnt + PW'(1);
                    if (last_beat) begin
                        r_d.st     = S_IDLE;
                        r_d.bfree  = 1'b1;
                        r_d.irq    = 1'b1;
                        r_d.wr_ptr = '0;
                        r_d.rd_ptr = '0;
                    end
                end
            end
            S_FIN: begin
                if (r_q.xlen != '0) begin
                    r_d.sync_word = {mem[0], mem[1]};
                    r_d.sync_load = 1'b1;
                end
                r_d.st     = S_IDLE;
                r_d.bfree  = 1'b1;
                r_d.irq    = 1'b1;
                r_d.wr_ptr = '0;
                r_d.rd_ptr = '0;
            end
            default: ;
        endcase

        // host writes
        if (host_wr) begin
            unique case (host_addr)
                A_DATA: begin
                    if (r_q.bfree && r_q.wr_ptr < PW'(DEPTH)) begin
                        buf_we     = 1'b1;
                        buf_waddr  = r_q.wr_ptr[AW-1:0];
                        buf_wdata  = host_wdata;
                        r_d.wr_ptr = r_q.wr_ptr + PW'(1);
                    end
                end
                A_MODE: begin
                    r_d.irqen = host_wdata[0];
                    if (r_q.bfree) begin
                        r_d.tx_mode = host_wdata[DW-1];
                    end
                end
                A_CMD: begin
                    if (dec_reset) begin
                        r_d.st        = S_IDLE;
                        r_d.bfree     = 1'b1;
                        r_d.irq       = 1'b0;
                        r_d.wr_ptr    = '0;
                        r_d.rd_ptr    = '0;
                        r_d.xcnt      = '0;
                        r_d.sync_load = 1'b0;
                    end else if (dec_issue && r_q.bfree) begin
                        r_d.bfree = 1'b0;
                        r_d.xcnt  = '0;
                        r_d.xlen  = dec_nbytes;
                        if (dec_data) begin
                            r_d.st = r_q.tx_mode ? S_TX : S_RX;
                        end else begin
                            r_d.st = S_FIN;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= S_IDLE;
            r_q.bfree     <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign host_rdata = r_q.rdata;
    assign irq_n      = ~(r_q.irq & r_q.irqen);
    assign tx_valid   = (r_q.st == S_TX);
    assign tx_byte    = mem[r_q.xcnt[AW-1:0]];
    assign rx_take    = (r_q.st == S_RX) && rx_enough;
    assign sync_load  = r_q.sync_load;
    assign sync_word  = r_q.sync_word;

endmodule

// File: rtl/mtc_chk.sv
module mtc_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_wr,
    input logic [1:0]    host_addr,
    input logic [DW-1:0] host_wdata,
    input logic          tx_valid,
    input logic          tx_ready,
    input logic [DW-1:0] tx_byte,
    input logic          rx_take,
    input logic          rx_enough,
    input logic          sync_load,
    input logic          bfree,
    input logic          irq,
    input logic          tx_mode
);

    logic cmd_issue;
    assign cmd_issue = host_wr && host_addr == 2'd0 &&
                       host_wdata[2:0] >= 3'd2 && host_wdata[2:0] <= 3'd5;

    // R3
    bfree_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bfree) |-> $past(cmd_issue));

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !(host_wr && host_addr == 2'd0 && host_wdata[2:0] == 3'd1))
        |=> (tx_valid && $stable(tx_byte)));

    // R5
    tx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !bfree);

    // R10
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_take |-> (rx_enough && !bfree));

    // R7
    irq_with_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> bfree);

    // R13
    mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_mode) |-> $past(bfree));

    // R11
    sync_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_load |-> (bfree && irq));

endmodule

bind modem_task_ctrl mtc_chk #(.DW(DW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_byte    (tx_byte),
    .rx_take    (rx_take),
    .rx_enough  (rx_enough),
    .sync_load  (sync_load),
    .bfree      (r_q.bfree),
    .irq        (r_q.irq),
    .tx_mode    (r_q.tx_mode)
);

// File: tb/test_modem_task_ctrl.sv
module test_modem_task_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq_n, tx_valid, rx_take, sync_load;
    logic        tx_ready = 1'b0, rx_enough = 1'b0, rx_valid = 1'b0;
    logic [7:0]  tx_byte, rx_byte = '0;
    logic [15:0] sync_word;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    modem_task_ctrl i_modem_task_ctrl (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq_n(irq_n), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
        .rx_enough(rx_enough), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_take(rx_take), .sync_load(sync_load), .sync_word(sync_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic t_reset_state();
        logic [7:0] v;
        chk("R1 irq_n", irq_n, 1); chk("R1 tx_valid", tx_valid, 0);
        chk("R1 rx_take", rx_take, 0); chk("R1 sync_load", sync_load, 0);
        rd(2'd2, v); chk("R1 R2 status", v, 8'h01);
    endtask

    task automatic t_block_tx();
        logic [7:0] v;
        wr(2'd3, 8'h81);
        rd(2'd3, v); chk("R2 mode readback", v, 8'h81);
        for (int i = 0; i < 8; i++) wr(2'd1, 8'h10 + 8'(i));
        tx_ready = 1'b1;
        wr(2'd0, 8'd5);
        for (int i = 0; i < 8; i++) begin
            chk("R5 R6 block valid", tx_valid, 1);
            chk("R5 block byte order", tx_byte, 8'h10 + 8'(i));
            @(negedge clk);
        end
        tx_ready = 1'b0;
        chk("R6 block ends after 8", tx_valid, 0);
        chk("R7 R8 irq_n after block", irq_n, 0);
        rd(2'd2, v); chk("R7 R9 status after block", v, 8'h83);
        chk("R9 irq_n after status read", irq_n, 1);
        rd(2'd2, v); chk("R9 irq cleared", v, 8'h81);
    endtask

    task automatic t_single_busy();
        logic [7:0] v;
        wr(2'd1, 8'hA5);
        wr(2'd0, 8'd4);
        chk("R5 single valid", tx_valid, 1); chk("R5 single byte0", tx_byte, 8'hA5);
        rd(2'd2, v); chk("R3 status busy", v, 8'h80);
        rd(2'd1, v); chk("R4 data read while busy", v, 8'h80);
        wr(2'd1, 8'h3C);
        wr(2'd0, 8'd5);
        chk("R5 stall holds valid", tx_valid, 1); chk("R5 stall holds byte", tx_byte, 8'hA5);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R4 R6 single only one byte", tx_valid, 0);
        chk("R8 irq_n single", irq_n, 0);
        rd(2'd2, v); chk("R7 status single", v, 8'h83);
    endtask

    task automatic t_lfsb();
        logic [7:0] v;
        wr(2'd0, 8'd3);
        chk("R11 no pulse yet", sync_load, 0);
        @(negedge clk);
        chk("R11 sync pulse", sync_load, 1);
        chk("R4 R11 sync word", sync_word, 16'hA511);
        @(negedge clk);
        chk("R11 pulse one cycle", sync_load, 0);
        rd(2'd2, v); chk("R11 status after lfsb", v, 8'h83);
    endtask

    task automatic t_tso_null();
        logic [7:0] v;
        tx_ready = 1'b1;
        wr(2'd0, 8'd2);
        chk("R6 tso no bytes", tx_valid, 0);
        @(negedge clk);
        chk("R6 tso no bytes later", tx_valid, 0);
        tx_ready = 1'b0;
        rd(2'd2, v); chk("R7 tso completes", v, 8'h83);
        wr(2'd0, 8'd0);
        wr(2'd0, 8'd6);
        chk("R3 null no transfer", tx_valid, 0);
        rd(2'd2, v); chk("R3 null/unused no effect", v, 8'h81);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        wr(2'd0, 8'd5);
        chk("R12 block pending", tx_valid, 1);
        wr(2'd0, 8'd1);
        chk("R12 reset stops tx", tx_valid, 0);
        chk("R12 irq_n after reset", irq_n, 1);
        rd(2'd2, v); chk("R12 status after reset", v, 8'h81);
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'd4);
        chk("R12 restart at byte0", tx_byte, 8'h5A);
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        rd(2'd2, v);
        wr(2'd3, 8'h80);
        wr(2'd1, 8'h01);
        tx_ready = 1'b1;
        wr(2'd0, 8'd4);
        @(negedge clk);
        tx_ready = 1'b0;
        chk("R8 irq_n masked", irq_n, 1);
        rd(2'd2, v); chk("R8 irq still flagged", v, 8'h83);
    endtask

    task automatic t_receive();
        logic [7:0] v;
        wr(2'd3, 8'h01);
        rd(2'd2, v); chk("R13 mode to receive", v, 8'h01);
        wr(2'd0, 8'd5);
        rx_valid = 1'b1; rx_byte = 8'hEE;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 no take before enough", rx_take, 0);
        end
        wr(2'd3, 8'h81);
        rd(2'd2, v); chk("R13 direction locked while busy", v, 8'h00);
        rx_enough = 1'b1;
        for (int i = 0; i < 8; i++) begin
            rx_byte = 8'hC0 + 8'(i);
            #0;
            chk("R10 take when enough", rx_take, 1);
            @(negedge clk);
        end
        rx_valid = 1'b0; rx_enough = 1'b0;
        chk("R10 take drops", rx_take, 0);
        chk("R13 R8 irqen still written", irq_n, 0);
        rd(2'd2, v); chk("R7 rx completion status", v, 8'h03);
        for (int i = 0; i < 8; i++) begin
            rd(2'd1, v); chk("R10 rx read order", v, 8'hC0 + 8'(i));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_block_tx();
        t_single_busy();
        t_lfsb();
        t_tso_null();
        t_abort();
        t_receive();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule